// File: doc/BRIEF.md
# Fan Voltage Controller Serial Slave

This block is the two-wire serial slave in front of a fan voltage regulator. It samples the bus clock and data lines with the system clock and finds START and STOP conditions. It answers one fixed 7-bit address and handles only two transactions. In a single-byte write, the host sends a command. In a single-byte read, the host collects a status byte. The block drives the data line only through an active-high pull-low enable, so it fits an open-drain pad.

A write carries a 6-bit output code and a boost-start enable bit. The code and the boost bit reach the outputs only at the falling clock edge that closes the command acknowledge, and a one-cycle update strobe marks that moment. A STOP that arrives before that edge throws the command away. A read returns two fault flags in the top two bits of the byte. The lower bits of that byte are zero.

Top module: `fanbus_slave`

## Requirements
- R1: After reset, dacCode is 0, boostEn is 0, sdaPullLow is 0 and codeUpdate is low.
- R2: The write address byte 0xE8 (7-bit address 1110100, R/W bit 0) is acknowledged by holding SDA low through the ninth clock, and the command byte that follows is acknowledged the same way.
- R3: At the falling SCL edge that ends the command acknowledge, dacCode takes command bits 5..0 (bit 5 is the MSB) and boostEn takes command bit 6. Bit 7 has no effect. codeUpdate pulses high for exactly one clock, and dacCode and boostEn change at no other time.
- R4: A STOP received after fewer than eight command bits leaves dacCode and boostEn unchanged and gives no codeUpdate pulse.
- R5: An address byte whose upper seven bits differ from 1110100 is not acknowledged. All bytes after it are neither acknowledged nor stored until the next START.
- R6: The read address byte 0xE9 is acknowledged. The slave then sends, MSB first and valid while SCL is high, a byte with bit 7 equal to faultOc, bit 6 equal to faultTherm and bits 5..0 equal to zero. The two fault flags are taken at the end of the address acknowledge.
- R7: A repeated START in the middle of an address or a command byte discards the partial byte and restarts address reception, so the transaction that follows completes normally.
- R8: sdaPullLow changes only while SCL is low.
- R9: During the ninth clock of a read the slave releases SDA so that the host's not-acknowledge is seen. After the STOP the bus accepts new transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on / undervoltage) |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| faultOc | input | 1 | Overcurrent fault flag |
| faultTherm | input | 1 | Thermal shutdown fault flag |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| dacCode | output | 6 | Committed output voltage code |
| boostEn | output | 1 | Committed boost-start enable |
| codeUpdate | output | 1 | One-clock strobe when a command is committed |

## Verification
The hardest case to reach is a transaction that is cut short at a chosen point. One example is a STOP after exactly k command bits, with k below eight. Another is a repeated START in the middle of the address or the command. Each must leave the committed code intact, and the bus must then recover for the next transfer. The bench drives the bus bit by bit from host tasks that take an abort position, and chooses that position at random from a fixed seed. A reference model keeps the expected code, the expected boost bit and the expected strobe count. Directed cases add address mismatches, reads with every combination of fault flags, and restarts inside both bytes.

// File: rtl/fanbus_pkg.sv
package fanbus_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = BYTE_W - 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_t;

  typedef struct packed {
    logic shiftIn;
    logic ackOn;
    logic txLoad;
    logic txShift;
    logic busFree;
    logic commit;
  } ctrl_strb_t;
endpackage

// File: rtl/fanbus_dp.sv
module fanbus_dp
  import fanbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h74,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              faultOc,
  input  logic              faultTherm,
  input  ctrl_strb_t        strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              addrHit,
  output logic              rwBit,
  output logic              sdaPullLow,
  output logic [CODE_W-1:0] dacCode,
  output logic              boostEn,
  output logic              codeUpdate
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe, sdaPipe;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic [BYTE_W-1:0] rxShift, txReg, statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclNow   = sclPipe[SYNC_STAGES-1];
  assign sclOld   = sclPipe[SYNC_STAGES];
  assign sdaNow   = sdaPipe[SYNC_STAGES-1];
  assign sdaOld   = sdaPipe[SYNC_STAGES];
  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;

  assign addrHit    = (rxShift[BYTE_W-1:1] == DEV_ADDR);
  assign rwBit      = rxShift[0];
  assign statusByte = {faultOc, faultTherm, {CODE_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      txReg      <= '0;
      sdaPullLow <= 1'b0;
      dacCode    <= '0;
      boostEn    <= 1'b0;
      codeUpdate <= 1'b0;
    end else begin
      codeUpdate <= strb.commit;
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaNow};
      if (strb.txLoad) begin
        txReg      <= statusByte;
        sdaPullLow <= ~statusByte[BYTE_W-1];
      end else if (strb.txShift) begin
        txReg      <= {txReg[BYTE_W-2:0], 1'b0};
        sdaPullLow <= ~txReg[BYTE_W-2];
      end else if (strb.ackOn) begin
        sdaPullLow <= 1'b1;
      end else if (strb.busFree) begin
        sdaPullLow <= 1'b0;
      end
      if (strb.commit) begin
        dacCode <= rxShift[CODE_W-1:0];
        boostEn <= rxShift[CODE_W];
      end
    end
  end

  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !$past(sclNow));

  // R8
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ackOn, strb.txLoad, strb.txShift, strb.busFree}));

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !codeUpdate |-> ($stable(dacCode) && $stable(boostEn)));

  // R3
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeUpdate |=> !codeUpdate);
endmodule

// File: rtl/fanbus_ctrl.sv
module fanbus_ctrl
  import fanbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       addrHit,
  input  logic       rwBit,
  output ctrl_strb_t strb
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    cntNxt   = bitCnt;
    if (startDet) begin
      stateNxt     = ST_ADDR;
      cntNxt       = '0;
      strb.busFree = 1'b1;
    end else if (stopDet) begin
      stateNxt     = ST_IDLE;
      strb.busFree = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD: begin
          if (sclRise && bitCnt < FULL) begin
            strb.shiftIn = 1'b1;
            cntNxt       = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            if (state == ST_ADDR && !addrHit) begin
              strb.busFree = 1'b1;
              stateNxt     = ST_IDLE;
            end else begin
              strb.ackOn = 1'b1;
              stateNxt   = (state == ST_ADDR) ? ST_ADDR_ACK : ST_CMD_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cntNxt = '0;
            if (rwBit) begin
              strb.txLoad = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              strb.busFree = 1'b1;
              stateNxt     = ST_CMD;
            end
          end
        end
        ST_CMD_ACK: begin
          if (sclFall) begin
            strb.commit  = 1'b1;
            strb.busFree = 1'b1;
            stateNxt     = ST_IDLE;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            cntNxt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              strb.busFree = 1'b1;
              stateNxt     = ST_TX_ACK;
            end else begin
              strb.txShift = 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclFall) stateNxt = ST_IDLE;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
    end
  end

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0));

  // R3
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> sclFall);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startDet) |=> (state == ST_IDLE));
endmodule

// File: rtl/fanbus_slave.sv
module fanbus_slave
  import fanbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h74,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              faultOc,
  input  logic              faultTherm,
  output logic              sdaPullLow,
  output logic [CODE_W-1:0] dacCode,
  output logic              boostEn,
  output logic              codeUpdate
);
  ctrl_strb_t strb;
  logic sclRise, sclFall, startDet, stopDet, addrHit, rwBit;

  fanbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .addrHit(addrHit),
    .rwBit(rwBit), .strb(strb)
  );

  fanbus_dp #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .faultOc(faultOc), .faultTherm(faultTherm), .strb(strb),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .addrHit(addrHit), .rwBit(rwBit),
    .sdaPullLow(sdaPullLow), .dacCode(dacCode), .boostEn(boostEn),
    .codeUpdate(codeUpdate)
  );
endmodule

// File: tb/tb_fanbus_slave.sv
module tb_fanbus_slave;
  localparam int Q = 8;

  logic clk = 0, rstN = 0;
  logic sclLine = 1, sdaHost = 1;
  logic faultOc = 0, faultTherm = 0;
  logic sdaPullLow, boostEn, codeUpdate;
  logic [5:0] dacCode;
  wire  sdaLine = sdaHost & ~sdaPullLow;

  int checks = 0, failures = 0, updCnt = 0, oeViol = 0;
  logic prevOe = 0, done = 0;
  logic [5:0] expCode = 0;
  logic expBoost = 0;
  int expUpd = 0;

  always #5 clk = ~clk;

  fanbus_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .faultOc(faultOc), .faultTherm(faultTherm), .sdaPullLow(sdaPullLow),
    .dacCode(dacCode), .boostEn(boostEn), .codeUpdate(codeUpdate)
  );

  always @(posedge clk) if (codeUpdate) updCnt++;
  always @(negedge clk) begin
    if (rstN && sdaPullLow != prevOe && sclLine) oeViol++;
    prevOe <= sdaPullLow;
  end

  function automatic logic [7:0] statusOf(logic oc, logic th);
    return {oc, th, 6'b000000};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaHost = 1; waitQ(); sclLine = 1; waitQ();
    sdaHost = 0; waitQ(); sclLine = 0; waitQ();
  endtask

  task automatic busStop();
    sdaHost = 0; waitQ(); sclLine = 1; waitQ(); sdaHost = 1; waitQ();
  endtask

  task automatic sendBit(logic b);
    sdaHost = b; waitQ(); sclLine = 1; waitQ(); sclLine = 0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaHost = 1; waitQ(); sclLine = 1; repeat (Q/2) @(negedge clk);
    b = sdaLine; repeat (Q/2) @(negedge clk); sclLine = 0; waitQ();
  endtask

  task automatic sendBits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) sendBit(v[i]);
  endtask

  task automatic sendByte(logic [7:0] v, output logic ack);
    sendBits(v, 8);
    readBit(ack);
  endtask

  // Write with the command cut after nBits bits (nBits == 8: full write)
  task automatic doWrite(logic [7:0] cmd, int nBits, string req);
    logic ack;
    busStart();
    sendByte(8'hE8, ack);
    chk({req, " R2 addr ack"}, ack, 0);
    if (nBits == 8) begin
      sendByte(cmd, ack);
      chk({req, " R2 cmd ack"}, ack, 0);
      expCode = cmd[5:0]; expBoost = cmd[6]; expUpd++;
    end else begin
      sendBits(cmd, nBits);
    end
    busStop();
    waitQ();
    chk({req, " code"}, dacCode, expCode);
    chk({req, " boost"}, boostEn, expBoost);
    chk({req, " update count"}, updCnt, expUpd);
  endtask

  task automatic doRead(logic oc, logic th);
    logic ack, b, nack;
    logic [7:0] got;
    faultOc = oc; faultTherm = th;
    busStart();
    sendByte(8'hE9, ack);
    chk("R6 read addr ack", ack, 0);
    for (int i = 7; i >= 0; i--) begin readBit(b); got[i] = b; end
    chk("R6 status byte", got, statusOf(oc, th));
    readBit(nack);
    chk("R9 nack released", nack, 1);
    busStop();
    chk("R9 sda free after stop", sdaPullLow, 0);
  endtask

  initial begin
    logic ack;
    int seedVal;
    seedVal = $urandom(32'd20231);
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    chk("R1 code", dacCode, 0);
    chk("R1 boost", boostEn, 0);
    chk("R1 sda", sdaPullLow, 0);
    chk("R1 update", updCnt, 0);

    doWrite(8'hFF, 8, "R3 full scale, bit7 ignored");
    doWrite(8'h15, 8, "R3 boost off");
    doWrite(8'h2A, 3, "R4 stop after 3 bits");
    doWrite(8'h40, 0, "R4 stop after 0 bits");
    doWrite(8'hC0, 8, "R3 code zero with boost");

    // R5 address mismatch: nothing acknowledged or stored
    busStart();
    sendByte(8'hD0, ack);
    chk("R5 wrong addr nack", ack, 1);
    sendByte(8'h3F, ack);
    chk("R5 following byte nack", ack, 1);
    busStop();
    waitQ();
    chk("R5 code kept", dacCode, expCode);
    chk("R5 no update", updCnt, expUpd);

    // R7 repeated start inside command byte
    busStart();
    sendByte(8'hE8, ack);
    sendBits(8'h3F, 3);
    doWrite(8'h27, 8, "R7 restart in command");
    // R7 repeated start inside address byte
    busStart();
    sendBits(8'hE8, 4);
    doWrite(8'h09, 8, "R7 restart in address");

    doRead(0, 0);
    doRead(1, 0);
    doRead(0, 1);
    doRead(1, 1);

    for (int n = 0; n < 24; n++) begin
      logic [7:0] cmd;
      int cut;
      cmd = 8'($urandom);
      cut = ($urandom % 3 == 0) ? int'($urandom % 8) : 8;
      case ($urandom % 4)
        0: doRead(1'($urandom), 1'($urandom));
        1: begin
          logic [7:0] bad;
          bad = {7'($urandom), 1'b0};
          if (bad[7:1] == 7'h74) bad[7:1] = 7'h75;
          busStart();
          sendByte(bad, ack);
          chk("R5 random wrong addr nack", ack, 1);
          sendByte(cmd, ack);
          busStop();
          waitQ();
          chk("R5 random code kept", dacCode, expCode);
        end
        default: doWrite(cmd, cut, cut == 8 ? "R3 random write" : "R4 random abort");
      endcase
    end

    chk("R8 sda changes only with scl low", oeViol, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule